// File: doc/BRIEF.md
# Digital Delta-Sigma Noise-Shaping Modulator

This block turns a wide signed sample stream, already running at the oversampled rate, into a single-bit stream that drives a two-level output stage. Each oversampled tick adds the current sample, an optional small pseudo-random dither word and a weighted sum of past truncation errors. The sign of that sum becomes the output bit. The bit stands for plus full scale when 1 and minus full scale when 0. The difference between the internal value and that decoded level is kept as the new error. The weights are chosen so that the error reaches the output through exactly (1 - z^-1)^L, where L is the loop order, while the input passes with unity gain. In-band noise therefore drops as the oversampling ratio rises.

Samples arrive on a valid/ready stream. The block is ready only on cycles where the oversampled clock-enable is high, and it never stalls beyond that. A tick with no valid sample reuses the last accepted sample, which is a zero-order hold. Internal sums and error registers saturate rather than wrap, so an overloaded loop recovers after the input returns to range or after a reset. Dither comes from a 16-bit maximal-length shift register and can be switched on and off at any time.

Top module: `dsm_modulator`

## Requirements
- R1: A synchronous active-high reset clears every error register and the held sample to zero, loads the dither register with 0xACE1 and drives bit_out to 0. bit_out stays 0 on the first cycle after reset is released.
- R2: in_ready equals tick. A sample transfers when in_valid and in_ready are both high, and that sample is used in the same tick. On a tick with in_valid low, the last transferred sample (zero after reset) is used.
- R3: On a cycle with tick low, bit_out, the error registers, the held sample and the dither register all keep their values.
- R4: On each tick the internal value is v = sat(x + sum over k=1..L of c_k·e[n-k] + d), with c_k = (-1)^(k+1)·C(L,k); for L=2 this gives c = (2, -1). bit_out is updated at the clock edge of the tick to 1 when v >= 0 and to 0 otherwise. Orders 1 to 3 are supported.
- R5: The output decodes as +FS for 1 and -FS for 0, with FS = 2^(IN_W-1). The stored error is e[n] = sat(v - decoded output), and older errors shift one place down the delay line.
- R6: sat() clamps to the range -2^(ACC_W-1) .. 2^(ACC_W-1)-1, with ACC_W = IN_W + ORDER + 3, and never wraps.
- R7: The dither register is a 16-bit Fibonacci shift register. It shifts left and takes in bit15^bit13^bit12^bit10 once per tick, whether or not dither is enabled. When dither_en is high, d is its low DITH_W bits read as a signed two's-complement number. When dither_en is low, d is 0.
- R8: For a constant input x within ±FS/2 held for N ticks, the sum of the decoded outputs differs from N·x by no more than 2^(ORDER+2)·FS + N·2^(DITH_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampled-rate clock-enable |
| dither_en | input | 1 | Adds LFSR dither when high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input accepted this cycle (equals tick) |
| in_data | input | IN_W | Signed input sample |
| bit_out | output | 1 | 1-bit modulator output (1 = +FS, 0 = -FS) |

## Verification
The assertions assume that tick and dither_en are free of unknowns and that the error-update check applies only while the internal value stays well inside the saturation range. The check is qualified on that condition, so overload runs do not trip it. Random stimulus keeps samples within ±FS/2 so that the order-2 loop stays stable while the mean-tracking tolerance is checked. Separate directed runs at both full-scale extremes push the loop into saturation, and each of those runs is followed by a reset.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  // Binomial coefficient C(n, k)
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  // Feedback weight on e[n-k] so that NTF = (1 - z^-1)^order
  function automatic int fb_coef(input int order, input int k);
    int c;
    c = binom(order, k);
    return (k % 2 == 1) ? c : -c;
  endfunction

endpackage

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [15:0] state
);
  logic fb_bit;

  assign fb_bit = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= {state[14:0], fb_bit};
  end
endmodule

// File: rtl/dsm_fb_sum.sv
module dsm_fb_sum
  import dsm_pkg::*;
#(
  parameter int ORDER = 2,
  parameter int ACC_W = 21,
  parameter int SUM_W = ACC_W + 5
) (
  input  logic [ORDER-1:0][ACC_W-1:0] err_line,
  output logic signed [SUM_W-1:0]     fb
);
  logic signed [SUM_W-1:0] term [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_tap
    localparam int COEF = fb_coef(ORDER, k + 1);
    logic signed [SUM_W-1:0] e_ext;
    assign e_ext   = SUM_W'($signed(err_line[k]));
    assign term[k] = SUM_W'(COEF) * e_ext;
  end

  always_comb begin
    fb = '0;
    for (int k = 0; k < ORDER; k++) fb = fb + term[k];
  end
endmodule

// File: rtl/dsm_quant.sv
module dsm_quant #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 21,
  parameter int SUM_W  = ACC_W + 5,
  parameter int DITH_W = 4
) (
  input  logic signed [IN_W-1:0]   x,
  input  logic signed [SUM_W-1:0]  fb,
  input  logic signed [DITH_W-1:0] dith,
  output logic signed [ACC_W-1:0]  v_sat,
  output logic                     bit_next,
  output logic signed [ACC_W-1:0]  err_next
);
  localparam longint LIM_HI = (longint'(1) << (ACC_W - 1)) - 1;
  localparam longint LIM_LO = -(longint'(1) << (ACC_W - 1));
  localparam longint FS     = longint'(1) << (IN_W - 1);
  localparam int     RAW_W  = SUM_W + 2;

  logic signed [RAW_W-1:0] v_raw;
  logic signed [ACC_W+1:0] e_raw;
  logic signed [ACC_W+1:0] y_lvl;

  assign v_raw = RAW_W'(x) + RAW_W'(fb) + RAW_W'(dith);

  always_comb begin
    if (v_raw > LIM_HI)      v_sat = ACC_W'(LIM_HI);
    else if (v_raw < LIM_LO) v_sat = ACC_W'(LIM_LO);
    else                     v_sat = ACC_W'(v_raw);
  end

  assign bit_next = ~v_sat[ACC_W-1];
  assign y_lvl    = bit_next ? (ACC_W+2)'(FS) : (ACC_W+2)'(-FS);
  assign e_raw    = (ACC_W+2)'(v_sat) - y_lvl;

  always_comb begin
    if (e_raw > LIM_HI)      err_next = ACC_W'(LIM_HI);
    else if (e_raw < LIM_LO) err_next = ACC_W'(LIM_LO);
    else                     err_next = ACC_W'(e_raw);
  end
endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
  parameter int          IN_W   = 16,
  parameter int          ORDER  = 2,
  parameter int          DITH_W = 4,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            dither_en,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            bit_out
);
  localparam int ACC_W = IN_W + ORDER + 3;
  localparam int SUM_W = ACC_W + 5;

  logic [ORDER-1:0][ACC_W-1:0] err_q;
  logic signed [IN_W-1:0]      x_hold;
  logic signed [IN_W-1:0]      x_cur;
  logic signed [SUM_W-1:0]     fb;
  logic signed [DITH_W-1:0]    dith;
  logic signed [ACC_W-1:0]     v_sat;
  logic signed [ACC_W-1:0]     err_next;
  logic                        bit_next;
  logic [15:0]                 lfsr_q;
  logic                        take;

  assign in_ready = tick;
  assign take     = tick & in_valid;
  assign x_cur    = take ? $signed(in_data) : x_hold;
  assign dith     = dither_en ? $signed(lfsr_q[DITH_W-1:0]) : '0;

  dsm_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(tick), .state(lfsr_q)
  );

  dsm_fb_sum #(.ORDER(ORDER), .ACC_W(ACC_W), .SUM_W(SUM_W)) u_fb (
    .err_line(err_q), .fb(fb)
  );

  dsm_quant #(.IN_W(IN_W), .ACC_W(ACC_W), .SUM_W(SUM_W), .DITH_W(DITH_W)) u_q (
    .x(x_cur), .fb(fb), .dith(dith),
    .v_sat(v_sat), .bit_next(bit_next), .err_next(err_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_hold  <= '0;
      bit_out <= 1'b0;
    end else if (tick) begin
      if (in_valid) x_hold <= $signed(in_data);
      bit_out <= bit_next;
    end
  end

  for (genvar k = 0; k < ORDER; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)       err_q[k] <= '0;
      else if (tick) err_q[k] <= (k == 0) ? err_next : err_q[(k == 0) ? 0 : k - 1];
    end
  end
endmodule

// File: rtl/dsm_modulator_chk.sv
module dsm_modulator_chk #(
  parameter int IN_W   = 16,
  parameter int ORDER  = 2,
  parameter int ACC_W  = 21,
  parameter int DITH_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick,
  input logic                    dither_en,
  input logic                    bit_out,
  input logic [ORDER*ACC_W-1:0]  err_flat,
  input logic signed [ACC_W-1:0] v_sat,
  input logic [15:0]             lfsr_q,
  input logic [DITH_W-1:0]       dith
);
  localparam longint FS   = longint'(1) << (IN_W - 1);
  localparam longint SAFE = longint'(1) << (ACC_W - 3);

  logic signed [ACC_W-1:0] e0;
  logic                    v_mid;
  assign e0    = $signed(err_flat[ACC_W-1:0]);
  assign v_mid = (longint'(v_sat) < SAFE) && (longint'(v_sat) > -SAFE);

  AST_RESET_OUT_LOW: assert property (@(posedge clk) rst |=> !bit_out); // R1
  AST_IDLE_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(bit_out)); // R3
  AST_IDLE_STATE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(err_flat) && $stable(lfsr_q))); // R3
  AST_ERR_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (tick && v_mid) |=> (longint'(e0) == longint'($past(v_sat)) - (bit_out ? FS : -FS))); // R5
  AST_DITHER_OFF: assert property (@(posedge clk) disable iff (rst)
    !dither_en |-> (dith == '0)); // R7
  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 16'h0); // R7

  for (genvar k = 1; k < ORDER; k++) begin : g_shift
    AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      tick |=> (err_flat[k*ACC_W +: ACC_W] == $past(err_flat[(k-1)*ACC_W +: ACC_W]))); // R5
  end
endmodule

bind dsm_modulator dsm_modulator_chk #(
  .IN_W(IN_W), .ORDER(ORDER), .ACC_W(ACC_W), .DITH_W(DITH_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .dither_en(dither_en),
  .bit_out(bit_out), .err_flat(err_q), .v_sat(v_sat),
  .lfsr_q(lfsr_q), .dith(dith)
);

// File: tb/sim_dsm_modulator.sv
module sim_dsm_modulator;
  localparam int     CLK_P  = 10;
  localparam int     IN_W   = 16;
  localparam int     ORDER  = 2;
  localparam int     DITH_W = 4;
  localparam int     ACC_W  = IN_W + ORDER + 3;
  localparam longint FS     = longint'(1) << (IN_W - 1);
  localparam longint HI     = (longint'(1) << (ACC_W - 1)) - 1;
  localparam longint LO     = -(longint'(1) << (ACC_W - 1));

  logic clk = 0, rst = 1, tick = 0, dither_en = 0, in_valid = 0;
  logic [IN_W-1:0] in_data = '0;
  logic in_ready, bit_out;
  int checks = 0, failures = 0;

  longint m_err [ORDER];
  longint m_xh;
  logic [15:0] m_lf;
  logic m_bit;

  always #(CLK_P/2) clk = ~clk;

  dsm_modulator #(.IN_W(IN_W), .ORDER(ORDER), .DITH_W(DITH_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .dither_en(dither_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .bit_out(bit_out)
  );

  function automatic longint sat(input longint a);
    if (a > HI) return HI;
    if (a < LO) return LO;
    return a;
  endfunction

  function automatic longint coef(input int k);
    longint c = 1;
    for (int i = 0; i < k; i++) c = c * (ORDER - i) / (i + 1);
    return (k % 2 == 1) ? c : -c;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; tick = 1; in_valid = 1; in_data = 16'h1234;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check(bit_out == 1'b0, "R1 reset output", bit_out, 0);
    for (int k = 0; k < ORDER; k++) m_err[k] = 0;
    m_xh = 0; m_lf = 16'hACE1; m_bit = 0;
    @(negedge clk); rst = 0; tick = 0; in_valid = 0;
    #1 check(bit_out == 1'b0, "R1 first cycle after reset", bit_out, 0);
  endtask

  task automatic step(input bit t, input bit vld, input longint xd, input bit den, input string req);
    longint xc, fb, d, v, y;
    @(negedge clk);
    tick = t; in_valid = vld; in_data = xd[IN_W-1:0]; dither_en = den;
    #1 check(in_ready == t, "R2 ready equals tick", in_ready, t);
    @(posedge clk);
    if (t) begin
      xc = vld ? xd : m_xh;
      if (vld) m_xh = xd;
      fb = 0;
      for (int k = 0; k < ORDER; k++) fb += coef(k + 1) * m_err[k];
      d = den ? longint'($signed(m_lf[DITH_W-1:0])) : 0;
      v = sat(xc + fb + d);
      y = (v >= 0) ? FS : -FS;
      for (int k = ORDER - 1; k > 0; k--) m_err[k] = m_err[k-1];
      m_err[0] = sat(v - y);
      m_bit = (v >= 0);
      m_lf = {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
    end
    #(CLK_P/4);
    check(bit_out == m_bit, req, bit_out, m_bit);
  endtask

  task automatic dc_run(input longint x, input int n, input bit den);
    longint acc = 0;
    longint tol = (longint'(1) << (ORDER + 2)) * FS + longint'(n) * (longint'(1) << (DITH_W - 1));
    longint diff;
    for (int i = 0; i < n; i++) begin
      step(1, 1, x, den, "R4 dc bitstream");
      acc += bit_out ? FS : -FS;
    end
    diff = acc - longint'(n) * x;
    check(diff <= tol && diff >= -tol, "R8 dc mean tracking", acc, longint'(n) * x);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint x;
    bit t, v, dn;
    void'($urandom(32'd7331));
    do_reset();
    // R1: zero state, first positive sample gives a 1
    step(1, 1, 100, 0, "R1 zero state first tick");
    // R2: hold of last sample when not valid
    step(1, 0, -20000, 0, "R2 reuse held sample");
    step(1, 0, 0, 0, "R2 reuse held sample");
    // R3: idle cycles with changing data
    for (int i = 0; i < 8; i++) step(0, 1, -30000 + i * 5000, 1, "R3 idle hold");
    // random mix: R4, R5, R7
    for (int i = 0; i < 3000; i++) begin
      t  = ($urandom % 10) < 7;
      v  = ($urandom % 10) < 8;
      dn = $urandom % 2;
      x  = longint'($urandom % 32768) - 16384;
      step(t, v, x, dn, dn ? "R7 dithered bitstream" : "R4 bitstream");
    end
    // R6: overload at both extremes drives saturation
    do_reset();
    for (int i = 0; i < 1500; i++) step(1, 1, -FS, 0, "R6 negative overload");
    do_reset();
    for (int i = 0; i < 1500; i++) step(1, 1, FS - 1, 1, "R6 positive overload");
    // R8: DC tracking
    do_reset();
    dc_run(FS / 4, 2048, 1);
    do_reset();
    dc_run(-FS / 3, 2048, 0);
    do_reset();
    dc_run(0, 1024, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule